// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Block

This block holds the control and status registers of a single general-purpose I/O port of up to sixteen pins. It sits on a simple 32-bit word-addressed bus and drives the pad-side signals: output level, output enable, input enable, pull bias, drive strength and slew. It also samples the pad inputs through a synchroniser. A four-bit function code per pin is exported so that a surrounding wrapper can route a peripheral onto the pin. Pad output is released only while the pin is in plain GPIO mode, which is function code 0.

Most single-bit-per-pin registers are written with a lane-enable scheme. The upper half of the write word says which pins the lower half may change, so software can flip one pin without first reading the register. Two mask registers sit in the pin path. One blocks input sampling. The other forces the pad output enable off whatever the output-enable register holds.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register is 0, and `pad_out`, `pad_oe`, `pad_ie`, `pad_slew`, `pad_pull`, `pad_drive` and `pin_func` are all 0.
- R2: The lane-enabled registers are output data (0x00), output enable (0x04), input enable (0x08), slew (0x2C), input mask (0x30) and output-enable mask (0x34). A write to one of them replaces bit n with `bus_wdata[n]` only when `bus_wdata[16+n]` is 1, and leaves bit n unchanged otherwise.
- R3: A read of a lane-enabled register returns the stored pin bits in the low half and 0 in bits 31:16.
- R4: Function codes live in words 0x10, 0x14, 0x18 and 0x1C. Pin p uses word p/4 at bits (p%4)*4+3:(p%4)*4. A field changes only when all four write-enable bits at 16+(p%4)*4 are 1, and a partial enable leaves it unchanged. `pin_func[4p+3:4p]` carries the code of pin p.
- R5: Pull bias (0x24) and drive strength (0x28) are plain full-word registers with 2 bits per pin at bit 2p. They drive `pad_pull` and `pad_drive`.
- R6: The input data word (0x20) is `pad_in` after a two-flop synchroniser, ANDed with input enable and with the inverse of the input mask. A change on `pad_in` shows up after the second rising edge, and writes to 0x20 have no effect.
- R7: `pad_oe[p]` = output enable AND NOT output-enable mask AND (function code of pin p == 0).
- R8: `pad_ie[p]` = input enable AND NOT input mask.
- R9: `pin_level[p]` returns the input data bit when the input enable of pin p is 1, and the output data bit when it is 0.
- R10: Reads of unmapped word offsets (0x0C, 0x38, 0x3C) return 0, and writes to them change nothing.
- R11: A write to output data with all enable bits 0 leaves `pad_out` unchanged.
- R12: `pad_out` follows the output data register and `pad_slew` follows the slew register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address in the port window |
| bus_wdata | input | 32 | Write data; upper half holds lane enables where used |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | PIN_COUNT | Asynchronous pad input levels |
| pad_out | output | PIN_COUNT | Pad output levels |
| pad_oe | output | PIN_COUNT | Pad output enables after masking and function gating |
| pad_ie | output | PIN_COUNT | Pad input enables after masking |
| pad_slew | output | PIN_COUNT | Per-pin slew select |
| pad_pull | output | PIN_COUNT*PULL_W | Per-pin pull bias code |
| pad_drive | output | PIN_COUNT*DRIVE_W | Per-pin drive strength code |
| pin_func | output | PIN_COUNT*FUNC_W | Per-pin function code for the wrapper |
| pin_level | output | PIN_COUNT | Current level of each pin as seen by software |

## Verification
The bench builds the block with its defaults: sixteen pins, four-bit function codes, two-bit pull and drive fields, and two synchroniser stages. With sixteen pins the whole upper half of the write word is used as lane enables. All four function words are populated, so a field in the top slot of the last word (pin 15) can be checked. The two-stage synchroniser makes its latency visible: input data must still be old after one edge and new after the second.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned HALF_W = 16;

   // Word index = byte offset / 4 within the port window
   localparam logic [3:0] WI_DOUT  = 4'd0;
   localparam logic [3:0] WI_OE    = 4'd1;
   localparam logic [3:0] WI_IE    = 4'd2;
   localparam logic [1:0] WI_FSEL_HI = 2'b01;   // words 4..7
   localparam logic [3:0] WI_DIN   = 4'd8;
   localparam logic [3:0] WI_PULL  = 4'd9;
   localparam logic [3:0] WI_DRIVE = 4'd10;
   localparam logic [3:0] WI_SLEW  = 4'd11;
   localparam logic [3:0] WI_IMSK  = 4'd12;
   localparam logic [3:0] WI_OEMSK = 4'd13;

endpackage

// File: rtl/gpio_lane_reg.sv
module gpio_lane_reg #(
   parameter int unsigned W = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [gpio_port_pkg::BUS_W-1:0]  wdata,
   output logic [W-1:0]                     q
);
   import gpio_port_pkg::*;

   logic [W-1:0] lane_en;
   logic [W-1:0] lane_val;

   assign lane_en  = wdata[HALF_W +: W];
   assign lane_val = wdata[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= (q & ~lane_en) | (lane_val & lane_en);
      end
   end

endmodule

// File: rtl/gpio_func_bank.sv
module gpio_func_bank #(
   parameter int unsigned PIN_COUNT = 16,
   parameter int unsigned FUNC_W    = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [1:0]                       sel,
   input  logic [gpio_port_pkg::BUS_W-1:0]  wdata,
   output logic [gpio_port_pkg::HALF_W-1:0] rdata,
   output logic [PIN_COUNT*FUNC_W-1:0]      func_flat
);
   import gpio_port_pkg::*;

   localparam int unsigned FPW = HALF_W / FUNC_W;

   logic [FUNC_W-1:0] code_q [PIN_COUNT];

   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      localparam int unsigned WORD = p / FPW;
      localparam int unsigned SLOT = p % FPW;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q[p] <= '0;
         end else if (wr_en && (sel == 2'(WORD)) &&
                      (&wdata[HALF_W + SLOT*FUNC_W +: FUNC_W])) begin
            code_q[p] <= wdata[SLOT*FUNC_W +: FUNC_W];
         end
      end

      assign func_flat[p*FUNC_W +: FUNC_W] = code_q[p];
   end

   always_comb begin
      rdata = '0;
      for (int p = 0; p < PIN_COUNT; p++) begin
         if (sel == 2'(p / FPW)) begin
            rdata[(p % FPW)*FUNC_W +: FUNC_W] = code_q[p];
         end
      end
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int unsigned PIN_COUNT   = 16,
   parameter int unsigned FUNC_W      = 4,
   parameter int unsigned PULL_W      = 2,
   parameter int unsigned DRIVE_W     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_we,
   input  logic [5:0]                    bus_addr,
   input  logic [31:0]                   bus_wdata,
   output logic [31:0]                   bus_rdata,
   input  logic [PIN_COUNT-1:0]          pad_in,
   output logic [PIN_COUNT-1:0]          pad_out,
   output logic [PIN_COUNT-1:0]          pad_oe,
   output logic [PIN_COUNT-1:0]          pad_ie,
   output logic [PIN_COUNT-1:0]          pad_slew,
   output logic [PIN_COUNT*PULL_W-1:0]   pad_pull,
   output logic [PIN_COUNT*DRIVE_W-1:0]  pad_drive,
   output logic [PIN_COUNT*FUNC_W-1:0]   pin_func,
   output logic [PIN_COUNT-1:0]          pin_level
);
   import gpio_port_pkg::*;

   localparam int unsigned FPW        = HALF_W / FUNC_W;
   localparam int unsigned FSEL_WORDS = (PIN_COUNT + FPW - 1) / FPW;
   localparam int unsigned PULL_BITS  = PIN_COUNT * PULL_W;
   localparam int unsigned DRV_BITS   = PIN_COUNT * DRIVE_W;
   localparam int unsigned LANE_REGS  = 6;

   // Elaboration-time parameter checks
   if (PIN_COUNT < 1 || PIN_COUNT > HALF_W) begin : g_bad_pins
      $error("PIN_COUNT must lie in 1..16");
   end
   if (FUNC_W < 1 || (HALF_W % FUNC_W) != 0 || FSEL_WORDS > 4) begin : g_bad_func
      $error("FUNC_W must divide 16 and fit the four function words");
   end
   if (PULL_BITS > BUS_W || DRV_BITS > BUS_W) begin : g_bad_fields
      $error("pull or drive fields exceed one word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [3:0] word;
   wire        unused_addr_lsb = ^bus_addr[1:0];
   assign word = bus_addr[5:2];

   // Lane-enabled registers, one instance per register, in this index order
   localparam logic [3:0] LANE_WI [LANE_REGS] = '{WI_DOUT, WI_OE, WI_IE, WI_SLEW, WI_IMSK, WI_OEMSK};
   logic [PIN_COUNT-1:0] lane_q [LANE_REGS];

   for (genvar r = 0; r < LANE_REGS; r++) begin : g_lane
      gpio_lane_reg #(.W(PIN_COUNT)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (bus_we && (word == LANE_WI[r])),
         .wdata (bus_wdata),
         .q     (lane_q[r])
      );
   end

   logic [PIN_COUNT-1:0] dout_q, oe_q, ie_q, slew_q, imsk_q, oemsk_q;
   assign dout_q  = lane_q[0];
   assign oe_q    = lane_q[1];
   assign ie_q    = lane_q[2];
   assign slew_q  = lane_q[3];
   assign imsk_q  = lane_q[4];
   assign oemsk_q = lane_q[5];

   // Function select bank
   logic [HALF_W-1:0] fsel_rdata;
   gpio_func_bank #(.PIN_COUNT(PIN_COUNT), .FUNC_W(FUNC_W)) u_func (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_we && (word[3:2] == WI_FSEL_HI)),
      .sel       (word[1:0]),
      .wdata     (bus_wdata),
      .rdata     (fsel_rdata),
      .func_flat (pin_func)
   );

   // Plain full-word pull and drive registers
   logic [PULL_BITS-1:0] pull_q;
   logic [DRV_BITS-1:0]  drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pull_q  <= '0;
         drive_q <= '0;
      end else if (bus_we) begin
         if (word == WI_PULL)  pull_q  <= bus_wdata[PULL_BITS-1:0];
         if (word == WI_DRIVE) drive_q <= bus_wdata[DRV_BITS-1:0];
      end
   end

   // Input path
   logic [PIN_COUNT-1:0] sync_q, din;
   gpio_in_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_q)
   );

   assign pad_ie = ie_q & ~imsk_q;
   assign din    = sync_q & pad_ie;

   // Pad outputs
   logic [PIN_COUNT-1:0] gpio_mode;
   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_mode
      assign gpio_mode[p] = (pin_func[p*FUNC_W +: FUNC_W] == '0);
   end

   assign pad_out   = dout_q;
   assign pad_oe    = oe_q & ~oemsk_q & gpio_mode;
   assign pad_slew  = slew_q;
   assign pad_pull  = pull_q;
   assign pad_drive = drive_q;
   assign pin_level = (ie_q & din) | (~ie_q & dout_q);

   // Read mux
   always_comb begin
      bus_rdata = '0;
      if (word[3:2] == WI_FSEL_HI) begin
         bus_rdata[HALF_W-1:0] = fsel_rdata;
      end else begin
         case (word)
            WI_DOUT:  bus_rdata[PIN_COUNT-1:0] = dout_q;
            WI_OE:    bus_rdata[PIN_COUNT-1:0] = oe_q;
            WI_IE:    bus_rdata[PIN_COUNT-1:0] = ie_q;
            WI_DIN:   bus_rdata[PIN_COUNT-1:0] = din;
            WI_PULL:  bus_rdata[PULL_BITS-1:0] = pull_q;
            WI_DRIVE: bus_rdata[DRV_BITS-1:0]  = drive_q;
            WI_SLEW:  bus_rdata[PIN_COUNT-1:0] = slew_q;
            WI_IMSK:  bus_rdata[PIN_COUNT-1:0] = imsk_q;
            WI_OEMSK: bus_rdata[PIN_COUNT-1:0] = oemsk_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
   parameter int unsigned PIN_COUNT = 16,
   parameter int unsigned FUNC_W    = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_we,
   input logic [5:0]                  bus_addr,
   input logic [31:0]                 bus_wdata,
   input logic [31:0]                 bus_rdata,
   input logic [PIN_COUNT-1:0]        pad_out,
   input logic [PIN_COUNT-1:0]        pad_oe,
   input logic [PIN_COUNT*FUNC_W-1:0] pin_func
);

   AST_RESET_CLEARS_PADS: assert property (@(posedge clk)
      !rst_n |=> (pad_oe == '0 && pad_out == '0 && pin_func == '0)); // R1

   AST_ZERO_ENABLE_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[5:2] == 4'd0 && bus_wdata[31:16] == 16'h0) |=> $stable(pad_out)); // R11

   AST_OE_MASK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[5:2] == 4'd13) |=>
         ((pad_oe & $past(bus_wdata[PIN_COUNT-1:0] & bus_wdata[16 +: PIN_COUNT])) == '0)); // R7

   AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[5:2] == 4'd3 || bus_addr[5:2] >= 4'd14) |-> (bus_rdata == '0)); // R10

   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_fn
      AST_FUNC_BLOCKS_OE: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_func[p*FUNC_W +: FUNC_W] != '0) |-> !pad_oe[p]); // R7
   end

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.PIN_COUNT(PIN_COUNT), .FUNC_W(FUNC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .pin_func  (pin_func)
);

// File: tb/gpio_port_regs_test.sv
`timescale 1ns/1ps
module gpio_port_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe, pad_ie, pad_slew, pin_level;
   logic [31:0] pad_pull, pad_drive;
   logic [63:0] pin_func;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_port_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_slew(pad_slew),
      .pad_pull(pad_pull), .pad_drive(pad_drive), .pin_func(pin_func),
      .pin_level(pin_level)
   );

   typedef struct packed {
      logic [5:0]  addr;
      logic [31:0] wdata;
      logic [31:0] expect_rd;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 19;
   localparam vec_t VECS [NVEC] = '{
      '{6'h00, 32'h00FF_00A5, 32'h0000_00A5, 4'd2},  // R2 low byte enabled
      '{6'h00, 32'hFF00_FFFF, 32'h0000_FFA5, 4'd2},  // R2 high byte only
      '{6'h00, 32'h0000_0000, 32'h0000_FFA5, 4'd11}, // R11 no enables
      '{6'h00, 32'h0001_0000, 32'h0000_FFA4, 4'd2},  // R2 clear bit 0
      '{6'h04, 32'hFFFF_00F0, 32'h0000_00F0, 4'd3},  // R3 upper half reads 0
      '{6'h08, 32'h0F00_0F00, 32'h0000_0F00, 4'd2},
      '{6'h10, 32'h000F_0003, 32'h0000_0003, 4'd4},  // R4 pin 0 = 3
      '{6'h10, 32'h00F0_0050, 32'h0000_0053, 4'd4},  // R4 pin 1 = 5
      '{6'h10, 32'h0700_0F00, 32'h0000_0053, 4'd4},  // R4 partial enable ignored
      '{6'h1C, 32'hF000_9000, 32'h0000_9000, 4'd4},  // R4 pin 15 = 9
      '{6'h24, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd5},  // R5
      '{6'h28, 32'h1234_5678, 32'h1234_5678, 4'd5},
      '{6'h2C, 32'h8001_FFFF, 32'h0000_8001, 4'd2},
      '{6'h30, 32'h0300_0100, 32'h0000_0100, 4'd2},
      '{6'h34, 32'h0030_0010, 32'h0000_0010, 4'd2},
      '{6'h0C, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10}, // R10
      '{6'h38, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10},
      '{6'h3C, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10},
      '{6'h20, 32'hFFFF_FFFF, 32'h0000_0000, 4'd6}   // R6 write ignored
   };

   task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic check_reset_state();
      logic [31:0] rd;
      for (int w = 0; w < 16; w++) begin
         bus_read(6'(w*4), rd);
         check(1, 64'(rd), 64'h0, $sformatf("reset read word %0d", w)); // R1
      end
      check(1, 64'(pad_out), 64'h0, "reset pad_out");
      check(1, 64'(pad_oe), 64'h0, "reset pad_oe");
      check(1, 64'(pad_ie), 64'h0, "reset pad_ie");
      check(1, 64'(pad_slew), 64'h0, "reset pad_slew");
      check(1, 64'(pad_pull), 64'h0, "reset pad_pull");
      check(1, 64'(pad_drive), 64'h0, "reset pad_drive");
      check(1, pin_func, 64'h0, "reset pin_func");
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_reset_state(); // R1

      for (int i = 0; i < NVEC; i++) begin
         bus_write(VECS[i].addr, VECS[i].wdata);
         bus_read(VECS[i].addr, rd);
         check(int'(VECS[i].req), 64'(rd), 64'(VECS[i].expect_rd),
               $sformatf("vector %0d addr %h", i, VECS[i].addr));
      end

      // R12 pad-side copies of stored registers
      check(12, 64'(pad_out), 64'h0000_FFA4, "pad_out follows output data");
      check(12, 64'(pad_slew), 64'h0000_8001, "pad_slew follows slew");
      // R5 pull and drive pad fields
      check(5, 64'(pad_pull), 64'hDEAD_BEEF, "pad_pull");
      check(5, 64'(pad_drive), 64'h1234_5678, "pad_drive");
      // R4 exported codes
      check(4, 64'(pin_func[3:0]), 64'h3, "pin_func pin 0");
      check(4, 64'(pin_func[7:4]), 64'h5, "pin_func pin 1");
      check(4, 64'(pin_func[63:60]), 64'h9, "pin_func pin 15");
      // R8 input enable gated by input mask
      check(8, 64'(pad_ie), 64'h0000_0E00, "pad_ie");
      // R7 oe bits 4..7, bit 4 masked
      check(7, 64'(pad_oe), 64'h0000_00E0, "pad_oe masked");
      bus_write(6'h14, 32'h00F0_0020); // pin 5 -> function 2
      check(4, 64'(pin_func[23:20]), 64'h2, "pin_func pin 5");
      check(7, 64'(pad_oe), 64'h0000_00C0, "pad_oe with pin 5 in peripheral mode");

      // R6 synchroniser latency and gating
      @(negedge clk);
      pad_in = 16'hFFFF;
      @(negedge clk);
      bus_addr = 6'h20;
      #1 check(6, 64'(bus_rdata), 64'h0, "input data after one edge");
      @(negedge clk);
      #1 check(6, 64'(bus_rdata), 64'h0000_0E00, "input data after two edges");
      // R9 level mux: ie pins take input, others take output data
      check(9, 64'(pin_level), 64'h0000_FEA4, "pin_level");

      // R10 unmapped writes changed nothing visible
      bus_read(6'h00, rd);
      check(10, 64'(rd), 64'h0000_FFA4, "output data untouched by unmapped writes");

      // R1 reset mid-run clears everything again
      @(negedge clk);
      pad_in = '0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check_reset_state();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule